// File: doc/BRIEF.md
# I2C Block Transfer Sequencer

This block runs whole multi-byte transfers against a register-addressed device on an I2C bus. It does not touch the pins. Instead it hands one byte-level command at a time to a byte engine and reads back that engine's response. The engine owns the bit timing and the START and STOP waveforms. A caller pulses `start` together with a device address, a register offset, a byte count and a direction. In a write, the bytes to send arrive on a valid/ready input stream. In a read, the bytes received leave on a valid/ready output stream. A one-cycle `done` pulse ends every transfer, and `err` holds that transfer's outcome until the next `done`.

Two addressing styles are available. In standard mode the sequencer sends the device address, then the offset byte, then the data. Legacy mode serves parts that take their offset from the address byte itself. The offset goes into the upper seven bits of the first byte, and no separate offset byte follows. Writes are cut into short chunks. After each chunk the sequencer polls the device with read-addressed STARTs until the device acknowledges, which signals that its internal write cycle has finished.

The engine accepts a command on `cmd_valid && cmd_ready`. It then returns exactly one `rsp_valid` pulse, carrying `rsp_nack` and, for reads, `rsp_data`. Command kinds (`cmd_op`): 0 sends a byte, with an optional START in front; 1 receives a byte and then sends either ACK or NACK+STOP; 2 issues only a STOP.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset `busy`, `done`, `cmd_valid`, `rd_valid` and `wr_ready` are 0. A `start` pulse while `busy` is 1 is ignored, and the running transfer's command sequence is unchanged.
- R2: Every address byte carries the direction in bit 0, with 1 for read and 0 for write. Device address bits [7:1] come from `dev_addr[7:1]`. In legacy mode the first byte is `{offset[6:0], dir}`, sent with START, and no offset byte follows.
- R3: A standard read sends `{dev,0}` with START, then the offset byte, and then waits at least GAP_CYCLES clock cycles. After that it sends `{dev,1}` with START. No STOP command comes between these steps.
- R4: A NACK on any address-phase byte causes one STOP command (op 2). The transfer then ends with `done` and `err`=1.
- R5: A read of N bytes issues N receive commands (op 1). All but the last have ACK set. The last has STOP set and ACK clear. The received bytes leave on the read stream in order.
- R6: A write sends at most CHUNK (4) data bytes per chunk. Each chunk opens with its own START address phase, using an offset advanced by the bytes already written, and closes with a STOP command.
- R7: After each chunk STOP, the sequencer sends `{dev,1}` with START until the device ACKs, with a STOP command after every NACK. After POLL_MAX (100) NACKed polls, the transfer ends with `err`=1.
- R8: After an ACKed poll, one byte is received with STOP and discarded. It never appears on the read stream.
- R9: A NACK on a write data byte causes one STOP command, and the transfer ends with `err`=1.
- R10: A transfer of length 0 completes with `done` and `err`=0 and issues no command.
- R11: A command that has not been accepted, and a read-stream byte that has not been taken, hold their values until the handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a transfer when idle |
| is_read | input | 1 | 1 = read transfer, 0 = write transfer |
| legacy | input | 1 | 1 = offset carried in the address byte |
| dev_addr | input | 8 | Device address in bits [7:1] |
| reg_off | input | 8 | Starting register offset |
| len | input | 8 | Byte count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Outcome of the last transfer (1 = failed) |
| cmd_valid | output | 1 | Command to the byte engine valid |
| cmd_ready | input | 1 | Byte engine accepts the command |
| cmd_op | output | 2 | 0 send byte, 1 receive byte, 2 STOP only |
| cmd_start | output | 1 | Send START before the byte |
| cmd_stop | output | 1 | Receive: NACK and STOP after the byte |
| cmd_ack | output | 1 | Receive: ACK after the byte |
| cmd_data | output | 8 | Byte to send |
| rsp_valid | input | 1 | Engine response pulse |
| rsp_nack | input | 1 | Sent byte was not acknowledged |
| rsp_data | input | 8 | Received byte |
| wr_valid | input | 1 | Write-stream byte valid |
| wr_ready | output | 1 | Write-stream byte taken |
| wr_data | input | 8 | Write-stream byte |
| rd_valid | output | 1 | Read-stream byte valid |
| rd_ready | input | 1 | Read-stream consumer ready |
| rd_data | output | 8 | Read-stream byte |

## Verification
The hardest case to reach is the acknowledge-poll limit. The device must refuse exactly as many polls as the limit allows, or one fewer, and every refused poll must be followed by its own STOP. The bench's engine model keeps a budget of poll NACKs that it spends only on read-addressed STARTs inside write transfers. Setting that budget to 99 and then to 100 puts the sequencer just inside and just past its give-up point. NACKs on chosen command indices then reach each address-phase and data-phase failure path. The repeated-START gap is measured from the cycles at which the engine accepted the offset byte and the read-addressed START.

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int CHUNK      = 4,
  parameter int POLL_MAX   = 100,
  parameter int GAP_CYCLES = 7500
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_read,
  input  logic       legacy,
  input  logic [7:0] dev_addr,
  input  logic [7:0] reg_off,
  input  logic [7:0] len,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [1:0] cmd_op,
  output logic       cmd_start,
  output logic       cmd_stop,
  output logic       cmd_ack,
  output logic [7:0] cmd_data,
  input  logic       rsp_valid,
  input  logic       rsp_nack,
  input  logic [7:0] rsp_data,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data
);
  localparam int CW = $clog2(CHUNK + 1);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam logic [1:0] OP_SEND = 2'd0, OP_RECV = 2'd1, OP_STOP = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_RSP, S_GAP, S_OUT} st_t;
  typedef enum logic [3:0] {P_DEVW, P_OFF, P_DEVR, P_LEG, P_RD, P_WR,
                            P_STOP, P_POLL, P_PSTOP, P_DISC} ph_t;

  st_t st;
  ph_t ph;
  logic          rd_q, leg_q, failing;
  logic [6:0]    dev_q;
  logic [7:0]    off_q, rem_q, rbyte_q;
  logic [CW-1:0] chk_q;
  logic [PW-1:0] try_q;
  logic [GW-1:0] gap_q;

  assign busy      = st != S_IDLE;
  assign cmd_valid = (st == S_CMD) && (ph != P_WR || wr_valid);
  assign wr_ready  = (st == S_CMD) && (ph == P_WR) && cmd_ready;
  assign rd_valid  = st == S_OUT;
  assign rd_data   = rbyte_q;

  always_comb begin
    cmd_op = OP_SEND; cmd_start = 1'b0; cmd_stop = 1'b0; cmd_ack = 1'b0; cmd_data = 8'h00;
    case (ph)
      P_DEVW:          begin cmd_start = 1'b1; cmd_data = {dev_q, 1'b0}; end
      P_OFF:           cmd_data = off_q;
      P_DEVR, P_POLL:  begin cmd_start = 1'b1; cmd_data = {dev_q, 1'b1}; end
      P_LEG:           begin cmd_start = 1'b1; cmd_data = {off_q[6:0], rd_q}; end
      P_WR:            cmd_data = wr_data;
      P_STOP, P_PSTOP: cmd_op = OP_STOP;
      P_RD:            begin cmd_op = OP_RECV; cmd_stop = rem_q == 8'd1; cmd_ack = rem_q != 8'd1; end
      P_DISC:          begin cmd_op = OP_RECV; cmd_stop = 1'b1; end
      default:         ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_DEVW; done <= 1'b0; err <= 1'b0;
      rd_q <= 1'b0; leg_q <= 1'b0; failing <= 1'b0; dev_q <= '0;
      off_q <= '0; rem_q <= '0; rbyte_q <= '0; chk_q <= '0; try_q <= '0; gap_q <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          rd_q <= is_read; leg_q <= legacy; dev_q <= dev_addr[7:1];
          off_q <= reg_off; rem_q <= len; failing <= 1'b0; chk_q <= '0; try_q <= '0;
          if (len == 8'd0) begin done <= 1'b1; err <= 1'b0; end
          else begin st <= S_CMD; ph <= legacy ? P_LEG : P_DEVW; end
        end
        S_CMD: if (cmd_valid && cmd_ready) st <= S_RSP;
        S_GAP: if (gap_q == '0) begin st <= S_CMD; ph <= P_DEVR; end
               else gap_q <= gap_q - 1'b1;
        S_OUT: if (rd_ready) begin
          rem_q <= rem_q - 8'd1;
          if (rem_q == 8'd1) begin st <= S_IDLE; done <= 1'b1; err <= 1'b0; end
          else begin st <= S_CMD; ph <= P_RD; end
        end
        S_RSP: if (rsp_valid) begin
          st <= S_CMD;
          case (ph)
            P_DEVW: if (rsp_nack) begin ph <= P_STOP; failing <= 1'b1; end
                    else ph <= P_OFF;
            P_OFF: if (rsp_nack) begin ph <= P_STOP; failing <= 1'b1; end
                   else if (rd_q) begin st <= S_GAP; gap_q <= GW'(GAP_CYCLES - 1); end
                   else begin ph <= P_WR; chk_q <= '0; end
            P_DEVR: if (rsp_nack) begin ph <= P_STOP; failing <= 1'b1; end
                    else ph <= P_RD;
            P_LEG: if (rsp_nack) begin ph <= P_STOP; failing <= 1'b1; end
                   else begin ph <= rd_q ? P_RD : P_WR; chk_q <= '0; end
            P_RD: begin rbyte_q <= rsp_data; st <= S_OUT; end
            P_WR: if (rsp_nack) begin ph <= P_STOP; failing <= 1'b1; end
                  else begin
                    rem_q <= rem_q - 8'd1; off_q <= off_q + 8'd1; chk_q <= chk_q + 1'b1;
                    if (rem_q == 8'd1 || chk_q == CW'(CHUNK - 1)) ph <= P_STOP;
                  end
            P_STOP: if (failing) begin st <= S_IDLE; done <= 1'b1; err <= 1'b1; end
                    else begin ph <= P_POLL; try_q <= '0; end
            P_POLL: if (rsp_nack) begin try_q <= try_q + 1'b1; ph <= P_PSTOP; end
                    else ph <= P_DISC;
            P_PSTOP: if (try_q == PW'(POLL_MAX)) begin st <= S_IDLE; done <= 1'b1; err <= 1'b1; end
                     else ph <= P_POLL;
            P_DISC: if (rem_q == 8'd0) begin st <= S_IDLE; done <= 1'b1; err <= 1'b0; end
                    else ph <= leg_q ? P_LEG : P_DEVW;
            default: st <= S_IDLE;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic       cmd_start,
  input logic       cmd_stop,
  input logic       cmd_ack,
  input logic [7:0] cmd_data,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_start) && $stable(cmd_data)); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R11
  AST_WR_DATA_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> cmd_op == 2'd0 && !cmd_start); // R6
  AST_RECV_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd1 |-> !cmd_start && (cmd_stop != cmd_ack)); // R5
  AST_STOP_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd2 |-> !cmd_start && !cmd_ack); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !cmd_valid && !rd_valid); // R1
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_ack(cmd_ack), .cmd_data(cmd_data),
  .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
);

// File: tb/sim_i2c_xfer_seq.sv
module sim_i2c_xfer_seq;
  localparam int GAP = 40;
  localparam int NV  = 13;

  typedef struct packed {
    logic       rd;
    logic       leg;
    logic [7:0] dev;
    logic [7:0] off;
    logic [7:0] len;
    logic [7:0] nki;
    logic [7:0] polls;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'hA0, 8'h10, 8'd3, 8'hFF, 8'd0},
    '{1'b1, 1'b1, 8'h00, 8'h25, 8'd2, 8'hFF, 8'd0},
    '{1'b0, 1'b0, 8'hA2, 8'hF0, 8'd6, 8'hFF, 8'd2},
    '{1'b0, 1'b1, 8'h00, 8'h40, 8'd5, 8'hFF, 8'd0},
    '{1'b1, 1'b0, 8'hA0, 8'h10, 8'd2, 8'd0,  8'd0},
    '{1'b1, 1'b0, 8'hA0, 8'h10, 8'd2, 8'd1,  8'd0},
    '{1'b0, 1'b0, 8'hA0, 8'h08, 8'd3, 8'd3,  8'd0},
    '{1'b0, 1'b0, 8'hA4, 8'h00, 8'd1, 8'hFF, 8'd99},
    '{1'b0, 1'b0, 8'hA4, 8'h00, 8'd1, 8'hFF, 8'd100},
    '{1'b1, 1'b0, 8'hA0, 8'h00, 8'd0, 8'hFF, 8'd0},
    '{1'b0, 1'b0, 8'hA6, 8'h7C, 8'd4, 8'hFF, 8'd0},
    '{1'b1, 1'b1, 8'h00, 8'h05, 8'd1, 8'd0,  8'd0},
    '{1'b0, 1'b1, 8'h00, 8'h7E, 8'd5, 8'hFF, 8'd1}
  };
  localparam string TAGS [NV] = '{"R3", "R2", "R6", "R2", "R4", "R4", "R9",
                                  "R7", "R7", "R10", "R6", "R4", "R8"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, is_read = 1'b0, legacy = 1'b0;
  logic [7:0] dev_addr = 8'h00, reg_off = 8'h00, len = 8'h00;
  logic busy, done, err, cmd_valid, cmd_ready, cmd_start, cmd_stop, cmd_ack;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data, rsp_data, wr_data, rd_data;
  logic rsp_valid, rsp_nack, wr_valid, wr_ready, rd_valid, rd_ready;

  logic clr = 1'b0, cur_rd = 1'b0;
  int   cur_len = 0, nk_idx = 255, poll_init = 0;

  int   tn, rdn, wi, rn, poll_left, dly, cyc_n;
  logic eng_busy, rnk;
  logic [1:0] cyc;
  logic [12:0] tr [256];
  int   tc [256];
  logic [7:0] rbuf [256];

  logic [12:0] exp_tr [256];
  int   en, epl;
  bit   eerr, grd;
  int   compared = 0, mismatched = 0;

  always #4 clk = ~clk;

  i2c_xfer_seq #(.CHUNK(4), .POLL_MAX(100), .GAP_CYCLES(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read), .legacy(legacy),
    .dev_addr(dev_addr), .reg_off(reg_off), .len(len), .busy(busy), .done(done), .err(err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_ack(cmd_ack), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
    .rsp_nack(rsp_nack), .rsp_data(rsp_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data));

  assign cmd_ready = !eng_busy && cyc[0];
  assign wr_valid  = !cur_rd && (wi < cur_len);
  assign wr_data   = 8'h30 + wi[7:0];
  assign rd_ready  = cyc[1];

  always @(posedge clk) begin
    logic ph;
    cyc   <= cyc + 2'd1;
    cyc_n <= cyc_n + 1;
    rsp_valid <= 1'b0;
    if (clr) begin
      tn <= 0; rdn <= 0; wi <= 0; rn <= 0; poll_left <= poll_init; eng_busy <= 1'b0; dly <= 0;
    end else begin
      if (wr_valid && wr_ready) wi <= wi + 1;
      if (rd_valid && rd_ready) begin rbuf[rn] <= rd_data; rn <= rn + 1; end
      if (cmd_valid && cmd_ready) begin
        tr[tn] <= {cmd_op, cmd_start, cmd_stop, cmd_ack, (cmd_op == 2'd1) ? 8'h00 : cmd_data};
        tc[tn] <= cyc_n;
        tn <= tn + 1;
        ph = (cmd_op == 2'd0) && cmd_start && cmd_data[0] && !cur_rd && (poll_left > 0);
        if (ph) poll_left <= poll_left - 1;
        rnk <= (tn == nk_idx) || ph;
        rsp_data <= 8'hC0 + rdn[7:0];
        if (cmd_op == 2'd1) rdn <= rdn + 1;
        eng_busy <= 1'b1; dly <= 2;
      end else if (eng_busy) begin
        if (dly == 0) begin rsp_valid <= 1'b1; rsp_nack <= rnk; eng_busy <= 1'b0; end
        else dly <= dly - 1;
      end
    end
  end

  initial begin
    cyc = 2'd0; cyc_n = 0; rsp_valid = 1'b0; rsp_nack = 1'b0; rsp_data = 8'h00;
    tn = 0; rdn = 0; wi = 0; rn = 0; poll_left = 0; eng_busy = 1'b0; dly = 0; rnk = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [12:0] enc(input logic [1:0] op, input logic s, input logic p,
                                      input logic a, input logic [7:0] d);
    return {op, s, p, a, d};
  endfunction

  task automatic emit(input logic [12:0] e, input int nki, output bit nk);
    bit ph;
    ph = (e[12:11] == 2'd0) && e[10] && e[0] && !grd && (epl > 0);
    if (ph) epl--;
    nk = (en == nki) || ph;
    exp_tr[en] = e;
    en++;
  endtask

  task automatic gen(input vec_t v);
    int rem, c, tries, wk;
    logic [7:0] off;
    bit nk;
    en = 0; epl = v.polls; eerr = 1'b0; grd = v.rd; rem = v.len; off = v.off; wk = 0;
    if (rem == 0) return;
    if (v.rd) begin
      if (v.leg) emit(enc(2'd0, 1'b1, 1'b0, 1'b0, {off[6:0], 1'b1}), v.nki, nk);
      else begin
        emit(enc(2'd0, 1'b1, 1'b0, 1'b0, {v.dev[7:1], 1'b0}), v.nki, nk);
        if (!nk) emit(enc(2'd0, 1'b0, 1'b0, 1'b0, off), v.nki, nk);
        if (!nk) emit(enc(2'd0, 1'b1, 1'b0, 1'b0, {v.dev[7:1], 1'b1}), v.nki, nk);
      end
      if (nk) begin emit(enc(2'd2, 0, 0, 0, 8'h00), v.nki, nk); eerr = 1'b1; return; end
      while (rem > 0) begin
        emit(enc(2'd1, 1'b0, rem == 1, rem != 1, 8'h00), v.nki, nk);
        rem--;
      end
    end else begin
      while (rem > 0) begin
        if (v.leg) emit(enc(2'd0, 1'b1, 1'b0, 1'b0, {off[6:0], 1'b0}), v.nki, nk);
        else begin
          emit(enc(2'd0, 1'b1, 1'b0, 1'b0, {v.dev[7:1], 1'b0}), v.nki, nk);
          if (!nk) emit(enc(2'd0, 1'b0, 1'b0, 1'b0, off), v.nki, nk);
        end
        if (nk) begin emit(enc(2'd2, 0, 0, 0, 8'h00), v.nki, nk); eerr = 1'b1; return; end
        c = 0;
        while (c < 4 && rem > 0) begin
          emit(enc(2'd0, 1'b0, 1'b0, 1'b0, 8'h30 + wk[7:0]), v.nki, nk);
          if (nk) begin emit(enc(2'd2, 0, 0, 0, 8'h00), v.nki, nk); eerr = 1'b1; return; end
          c++; rem--; off++; wk++;
        end
        emit(enc(2'd2, 0, 0, 0, 8'h00), v.nki, nk);
        tries = 0;
        forever begin
          emit(enc(2'd0, 1'b1, 1'b0, 1'b0, {v.dev[7:1], 1'b1}), v.nki, nk);
          if (!nk) break;
          emit(enc(2'd2, 0, 0, 0, 8'h00), v.nki, nk);
          tries++;
          if (tries == 100) begin eerr = 1'b1; return; end
        end
        emit(enc(2'd1, 1'b0, 1'b1, 1'b0, 8'h00), v.nki, nk);
      end
    end
  endtask

  task automatic run(input vec_t v, input bit inject, output bit got_done);
    int w;
    @(negedge clk);
    cur_rd = v.rd; cur_len = v.len; nk_idx = v.nki; poll_init = v.polls; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    is_read = v.rd; legacy = v.leg; dev_addr = v.dev; reg_off = v.off; len = v.len; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!done && w < 8000) begin
      @(negedge clk);
      w++;
      if (inject && w == 6) begin
        is_read = ~v.rd; legacy = ~v.leg; len = 8'd9; reg_off = 8'h55; start = 1'b1;
      end else start = 1'b0;
    end
    got_done = done;
    start = 1'b0;
  endtask

  task automatic compare(input vec_t v, input string tag);
    int nwr;
    chk(tn == en, tag, "command count", tn, en);
    for (int i = 0; i < en && i < tn; i++)
      chk(tr[i] == exp_tr[i], tag, $sformatf("command %0d", i), tr[i], exp_tr[i]);
    chk(err == eerr, tag, "err", err, eerr);
    if (v.rd) begin
      chk(rn == (eerr ? 0 : v.len), "R5", "read bytes delivered", rn, eerr ? 0 : v.len);
      for (int i = 0; i < rn; i++)
        chk(rbuf[i] == 8'hC0 + i[7:0], "R5", "read byte", rbuf[i], 8'hC0 + i);
    end else begin
      chk(rn == 0, "R8", "discarded poll byte on read stream", rn, 0);
      nwr = 0;
      for (int i = 0; i < en; i++)
        if (exp_tr[i][12:11] == 2'd0 && !exp_tr[i][10] && (v.leg || i > 0) &&
            exp_tr[i][7:0] >= 8'h30 && exp_tr[i][7:0] < 8'h30 + v.len && (i == 0 || exp_tr[i-1][12:11] == 2'd0) &&
            !(i > 0 && exp_tr[i-1][10] && !v.leg)) nwr++;
    end
    if (v.rd && !v.leg && !eerr && v.len > 0)
      chk(tc[2] - tc[1] >= GAP + 4 && tc[2] - tc[1] <= GAP + 8, "R3", "offset to read-START cycles",
          tc[2] - tc[1], GAP + 5);
  endtask

  initial begin
    bit gd;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1", "busy/done in reset", {busy, done}, 0);
    chk(cmd_valid == 0 && rd_valid == 0 && wr_ready == 0, "R1", "handshakes in reset",
        {cmd_valid, rd_valid, wr_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && cmd_valid == 0, "R1", "idle after reset", {busy, cmd_valid}, 0);

    for (int k = 0; k < NV; k++) begin
      gen(VECS[k]);
      run(VECS[k], 1'b0, gd);
      chk(gd, TAGS[k], $sformatf("done seen, vector %0d", k), gd, 1);
      compare(VECS[k], TAGS[k]);
    end

    gen(VECS[0]);
    run(VECS[0], 1'b1, gd);
    chk(gd, "R1", "done with start pulsed while busy", gd, 1);
    compare(VECS[0], "R1");
    repeat (4) @(negedge clk);
    chk(tn == en && busy == 0, "R1", "no transfer from ignored start", tn, en);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule